// File: doc/BRIEF.md
# Grid multiplex and dimming sequencer for a vacuum fluorescent display

This block scans a multiplexed vacuum fluorescent display. A frame is split into time slots, one per active grid plus a final slot set aside for key scanning. During each grid slot the block reads three bytes of digit data from an external display RAM, lights that grid, and gates its segments with a pulse width chosen by a 3-bit dimming code. Each slot is sixteen sub-periods long; one sub-period ends on each pulse of `sub_tick`.

The grid count ranges from 4 to 12. Grids and segments share a pool of 28 output pins: dedicated segment pins 1 to 16, dedicated grid pins 1 to 4, and eight shared pins that carry either segments 17 to 24 or grids 12 down to 5. With n grids the display has 28 - n segments. A mode write that changes the grid count switches the display off, and a control write switches it on or off and sets the dimming code. The RAM has a read latency of one clock. `sub_tick` pulses must be at least six clocks apart, and none may come within six clocks after a control write that turns the display on, so that each digit fetch finishes during the blanked leading sub-period.

State machine: FS_OFF (display off), FS_ISSUE (byte 0 address driven), FS_TAKE0 / FS_TAKE1 / FS_TAKE2 (each captures one returned byte), FS_SHOW (pattern held). Transitions: power-up (FS_OFF to FS_ISSUE when the display turns on), the fixed walk FS_ISSUE to FS_TAKE0 to FS_TAKE1 to FS_TAKE2 to FS_SHOW, slot start (FS_SHOW to FS_ISSUE when a new grid slot begins; the key slot starts no fetch), and shutdown (any state to FS_OFF when the display is off).

Top module: `vfd_mux_seq`

## Requirements
- R1: After reset the block has 12 grids, the display is off, the dimming code is 0, and all segment, grid and key-slot outputs are 0; switched on without a mode write, a frame lasts 13 slots.
- R2: A mode write with code c in 0..7 selects 4 + c grids, and any code with bit 3 set selects 12 grids. A frame is n + 1 slots of 16 sub-periods. In slot i < n only grid i + 1 is driven, and it stays driven for the whole slot.
- R3: A mode write that changes the grid count turns the display off from the next clock. A mode write of the grid count already in effect leaves the display running. A control write in the same clock as a changing mode write is dropped.
- R4: A control write loads the on flag (`ctl_on`) and the dimming code. While off, all outputs are 0. Switching on restarts the frame in slot 0, sub-period 0, with grid 1 driven from the next clock.
- R5: In the slot of grid i (numbered from 0), segment s (numbered from 1) shows bit (s - 1) mod 8 of RAM byte 3i + (s - 1) div 8.
- R6: Segments are lit only in sub-periods 1 through w of a grid slot, where w for dimming codes 0 to 7 is 1, 2, 4, 10, 11, 12, 13, 14. Sub-period 0 is always dark.
- R7: Shared pin j (0..7) carries segment 17 + j when j < 12 - n, and grid 12 - j otherwise.
- R8: In the key-scan slot (slot n), every grid and segment output is 0 and `key_slot_o` is 1. Outside that slot `key_slot_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | One pulse per sub-period |
| mode_wr | input | 1 | Mode write strobe |
| mode_code | input | 4 | Grid-count code |
| ctl_wr | input | 1 | Control write strobe |
| ctl_on | input | 1 | Display on flag for a control write |
| ctl_dim | input | 3 | Dimming code for a control write |
| ram_addr | output | 6 | Display RAM read address |
| ram_data | input | 8 | Display RAM read data, one clock after the address |
| seg_o | output | 16 | Dedicated segment pins 1 to 16 |
| shr_o | output | 8 | Shared pins: segments 17 to 24 or grids 12 down to 5 |
| grid_o | output | 4 | Dedicated grid pins 1 to 4 |
| key_slot_o | output | 1 | High during the key-scan slot |

## Verification
The bench builds the block with its default parameters and sends sub-period ticks every eight clocks, so every slot is 128 clocks long. It uses mode codes 0, 3, 9 and 15. These cover a shared pool used entirely for segments, a split pool, and a pool used entirely for grids, and they also exercise a changing mode write and a mode write that changes nothing. Dimming codes 0, 3, 5 and 7 run against a model that fixes the lit window for every sub-period. A display RAM of 36 distinct bytes makes any error in the fetch address or the byte lane show up on the pins.

// File: rtl/vfd_seq_pkg.sv
package vfd_seq_pkg;
    localparam int SUB_N      = 16;
    localparam int SUB_W      = $clog2(SUB_N);
    localparam int MIN_GRID   = 4;
    localparam int MAX_GRID   = 12;
    localparam int CNT_W      = $clog2(MAX_GRID + 1);
    localparam int BYTE_W     = 8;
    localparam int DIGIT_BYTES = 3;
    localparam int SEG_N      = DIGIT_BYTES * BYTE_W;
    localparam int PIN_N      = SEG_N + MIN_GRID;
    localparam int DED_SEG    = PIN_N - MAX_GRID;
    localparam int SHARED_N   = SEG_N - DED_SEG;
    localparam int ADDR_W     = $clog2(MAX_GRID * DIGIT_BYTES);
    localparam int DIM_W      = 3;

    typedef enum logic [2:0] {
        FS_OFF,
        FS_ISSUE,
        FS_TAKE0,
        FS_TAKE1,
        FS_TAKE2,
        FS_SHOW
    } fetch_st_t;
endpackage

// File: rtl/vfd_mode_regs.sv
module vfd_mode_regs
    import vfd_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [3:0]       mode_code,
    input  logic             ctl_wr,
    input  logic             ctl_on,
    input  logic [DIM_W-1:0] ctl_dim,
    output logic [CNT_W-1:0] grid_cnt,
    output logic             disp_on,
    output logic [DIM_W-1:0] dim_code
);
    logic [CNT_W-1:0] req_cnt;
    logic             mode_change;

    always_comb begin
        req_cnt     = mode_code[3] ? CNT_W'(MAX_GRID)
                                   : CNT_W'(MIN_GRID) + CNT_W'(mode_code[2:0]);
        mode_change = mode_wr && (req_cnt != grid_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grid_cnt <= CNT_W'(MAX_GRID);
            disp_on  <= 1'b0;
            dim_code <= '0;
        end else if (mode_change) begin
            grid_cnt <= req_cnt;
            disp_on  <= 1'b0;
        end else if (ctl_wr) begin
            disp_on  <= ctl_on;
            dim_code <= ctl_dim;
        end
    end
endmodule

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer
    import vfd_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_on,
    input  logic             sub_tick,
    input  logic [CNT_W-1:0] grid_cnt,
    output logic [CNT_W-1:0] slot_idx,
    output logic [SUB_W-1:0] sub_idx,
    output logic             fetch_go
);
    logic             slot_end;
    logic [CNT_W-1:0] slot_nxt;

    always_comb begin
        slot_end = disp_on && sub_tick && (sub_idx == SUB_W'(SUB_N - 1));
        slot_nxt = (slot_idx == grid_cnt) ? '0 : slot_idx + 1'b1;
        fetch_go = slot_end && (slot_nxt != grid_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_idx <= '0;
            sub_idx  <= '0;
        end else if (!disp_on) begin
            slot_idx <= '0;
            sub_idx  <= '0;
        end else if (sub_tick) begin
            sub_idx <= sub_idx + 1'b1;
            if (slot_end) begin
                slot_idx <= slot_nxt;
            end
        end
    end
endmodule

// File: rtl/vfd_fetch_fsm.sv
module vfd_fetch_fsm
    import vfd_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_on,
    input  logic              fetch_go,
    input  logic [CNT_W-1:0]  slot_idx,
    input  logic [BYTE_W-1:0] ram_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [SEG_N-1:0]  pattern
);
    fetch_st_t st, st_nx;
    logic [1:0]        rd_ofs;
    logic              cap_en;
    logic [1:0]        cap_lane;
    logic [ADDR_W-1:0] base;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FS_OFF;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            FS_OFF:   st_nx = disp_on ? FS_ISSUE : FS_OFF;
            FS_ISSUE: st_nx = FS_TAKE0;
            FS_TAKE0: st_nx = FS_TAKE1;
            FS_TAKE1: st_nx = FS_TAKE2;
            FS_TAKE2: st_nx = FS_SHOW;
            FS_SHOW:  st_nx = fetch_go ? FS_ISSUE : FS_SHOW;
            default:  st_nx = FS_OFF;
        endcase
        if (!disp_on) st_nx = FS_OFF;
    end

    // outputs of each state
    always_comb begin
        rd_ofs   = 2'd0;
        cap_en   = 1'b0;
        cap_lane = 2'd0;
        unique case (st)
            FS_TAKE0: begin rd_ofs = 2'd1; cap_en = 1'b1; cap_lane = 2'd0; end
            FS_TAKE1: begin rd_ofs = 2'd2; cap_en = 1'b1; cap_lane = 2'd1; end
            FS_TAKE2: begin cap_en = 1'b1; cap_lane = 2'd2; end
            default:  ;
        endcase
        base     = ADDR_W'(slot_idx) * ADDR_W'(DIGIT_BYTES);
        ram_addr = base + ADDR_W'(rd_ofs);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pattern <= '0;
        end else if (cap_en) begin
            pattern[cap_lane*BYTE_W +: BYTE_W] <= ram_data;
        end
    end
endmodule

// File: rtl/vfd_pin_map.sv
module vfd_pin_map
    import vfd_seq_pkg::*;
(
    input  logic                disp_on,
    input  logic [CNT_W-1:0]    grid_cnt,
    input  logic [DIM_W-1:0]    dim_code,
    input  logic [CNT_W-1:0]    slot_idx,
    input  logic [SUB_W-1:0]    sub_idx,
    input  logic [SEG_N-1:0]    pattern,
    output logic [DED_SEG-1:0]  seg_o,
    output logic [SHARED_N-1:0] shr_o,
    output logic [MIN_GRID-1:0] grid_o,
    output logic                key_slot_o
);
    logic               in_grid;
    logic               lit;
    logic [SUB_W-1:0]   width;
    logic [SEG_N-1:0]   seg_l;
    logic [MAX_GRID-1:0] grid_l;
    logic [CNT_W-1:0]   seg_shared;

    always_comb begin
        unique case (dim_code)
            3'd0:    width = SUB_W'(1);
            3'd1:    width = SUB_W'(2);
            3'd2:    width = SUB_W'(4);
            3'd3:    width = SUB_W'(10);
            3'd4:    width = SUB_W'(11);
            3'd5:    width = SUB_W'(12);
            3'd6:    width = SUB_W'(13);
            default: width = SUB_W'(14);
        endcase
        in_grid    = disp_on && (slot_idx < grid_cnt);
        lit        = in_grid && (sub_idx != '0) && (sub_idx <= width);
        seg_l      = lit ? pattern : '0;
        key_slot_o = disp_on && (slot_idx == grid_cnt);
        seg_shared = CNT_W'(MAX_GRID) - grid_cnt;
        seg_o      = seg_l[DED_SEG-1:0];
        grid_o     = grid_l[MIN_GRID-1:0];
    end

    for (genvar g = 0; g < MAX_GRID; g++) begin : g_grid
        assign grid_l[g] = in_grid && (slot_idx == CNT_W'(g));
    end

    for (genvar j = 0; j < SHARED_N; j++) begin : g_shared
        assign shr_o[j] = (CNT_W'(j) < seg_shared) ? seg_l[DED_SEG + j]
                                                   : grid_l[MAX_GRID - 1 - j];
    end
endmodule

// File: rtl/vfd_mux_seq.sv
module vfd_mux_seq
    import vfd_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sub_tick,
    input  logic                mode_wr,
    input  logic [3:0]          mode_code,
    input  logic                ctl_wr,
    input  logic                ctl_on,
    input  logic [DIM_W-1:0]    ctl_dim,
    output logic [ADDR_W-1:0]   ram_addr,
    input  logic [BYTE_W-1:0]   ram_data,
    output logic [DED_SEG-1:0]  seg_o,
    output logic [SHARED_N-1:0] shr_o,
    output logic [MIN_GRID-1:0] grid_o,
    output logic                key_slot_o
);
    logic [CNT_W-1:0] grid_cnt;
    logic             disp_on;
    logic [DIM_W-1:0] dim_code;
    logic [CNT_W-1:0] slot_idx;
    logic [SUB_W-1:0] sub_idx;
    logic             fetch_go;
    logic [SEG_N-1:0] pattern;

    vfd_mode_regs i_regs (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
        .ctl_wr(ctl_wr), .ctl_on(ctl_on), .ctl_dim(ctl_dim),
        .grid_cnt(grid_cnt), .disp_on(disp_on), .dim_code(dim_code)
    );

    vfd_slot_timer i_timer (
        .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .sub_tick(sub_tick),
        .grid_cnt(grid_cnt), .slot_idx(slot_idx), .sub_idx(sub_idx),
        .fetch_go(fetch_go)
    );

    vfd_fetch_fsm i_fetch (
        .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .fetch_go(fetch_go),
        .slot_idx(slot_idx), .ram_data(ram_data), .ram_addr(ram_addr),
        .pattern(pattern)
    );

    vfd_pin_map i_pins (
        .disp_on(disp_on), .grid_cnt(grid_cnt), .dim_code(dim_code),
        .slot_idx(slot_idx), .sub_idx(sub_idx), .pattern(pattern),
        .seg_o(seg_o), .shr_o(shr_o), .grid_o(grid_o), .key_slot_o(key_slot_o)
    );
endmodule

// File: rtl/vfd_mux_seq_chk.sv
module vfd_mux_seq_chk
    import vfd_seq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                on,
    input logic [CNT_W-1:0]    grids,
    input logic [CNT_W-1:0]    slot,
    input logic [SUB_W-1:0]    sub,
    input logic                tick,
    input logic                mode_wr,
    input logic [3:0]          mode_code,
    input logic [DED_SEG-1:0]  seg_o,
    input logic [SHARED_N-1:0] shr_o,
    input logic [MIN_GRID-1:0] grid_o,
    input logic                key_o
);
    logic [CNT_W-1:0] req_n;
    always_comb req_n = mode_code[3] ? CNT_W'(MAX_GRID)
                                     : CNT_W'(MIN_GRID) + CNT_W'(mode_code[2:0]);

    AST_MODE_CHANGE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && req_n != grids) |=> !on); // R3
    AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !on |-> (seg_o == '0 && shr_o == '0 && grid_o == '0 && !key_o)); // R4
    AST_ONE_GRID: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grid_o)); // R2
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        on |-> slot <= grids); // R2
    AST_SUB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (on && !tick) |=> $stable(sub)); // R2
    AST_LEAD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (sub == '0) |-> seg_o == '0); // R6
    AST_KEY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        key_o |-> (grid_o == '0 && seg_o == '0)); // R8
endmodule

bind vfd_mux_seq vfd_mux_seq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .on(disp_on), .grids(grid_cnt), .slot(slot_idx),
    .sub(sub_idx), .tick(sub_tick), .mode_wr(mode_wr), .mode_code(mode_code),
    .seg_o(seg_o), .shr_o(shr_o), .grid_o(grid_o), .key_o(key_slot_o)
);

// File: tb/test_vfd_mux_seq.sv
`timescale 1ns/1ps
module test_vfd_mux_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sub_tick = 1'b0;
    logic        mode_wr = 1'b0;
    logic [3:0]  mode_code = 4'd0;
    logic        ctl_wr = 1'b0;
    logic        ctl_on = 1'b0;
    logic [2:0]  ctl_dim = 3'd0;
    logic [5:0]  ram_addr;
    logic [7:0]  ram_data = 8'd0;
    logic [15:0] seg_o;
    logic [7:0]  shr_o;
    logic [3:0]  grid_o;
    logic        key_slot_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit cmp_en = 0;
    int tcnt = 0;

    logic [7:0] mem [0:35];

    // model state
    int  m_n = 12, m_on = 0, m_dim = 0, m_slot = 0, m_sub = 0;

    always #2.5 clk = ~clk;

    vfd_mux_seq i_vfd_mux_seq (
        .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .mode_wr(mode_wr),
        .mode_code(mode_code), .ctl_wr(ctl_wr), .ctl_on(ctl_on), .ctl_dim(ctl_dim),
        .ram_addr(ram_addr), .ram_data(ram_data), .seg_o(seg_o), .shr_o(shr_o),
        .grid_o(grid_o), .key_slot_o(key_slot_o)
    );

    initial for (int a = 0; a < 36; a++) mem[a] = 8'((a * 73 + 29) ^ 8'hA5);

    always @(posedge clk) ram_data <= (ram_addr < 6'd36) ? mem[ram_addr] : 8'h00;

    // sub-period ticks every 8 clocks
    always @(negedge clk) begin
        tcnt = (tcnt == 7) ? 0 : tcnt + 1;
        sub_tick = rst_n && (tcnt == 0);
    end

    function automatic int width_of(input int k);
        int t [8] = '{1, 2, 4, 10, 11, 12, 13, 14};
        return t[k];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference, updated on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = 12; m_on = 0; m_dim = 0; m_slot = 0; m_sub = 0;
        end else begin
            int nn;
            bit chg;
            if (m_on == 0) begin
                m_slot = 0; m_sub = 0;
            end else if (sub_tick) begin
                if (m_sub == 15) begin
                    m_sub = 0;
                    m_slot = (m_slot == m_n) ? 0 : m_slot + 1;
                end else m_sub = m_sub + 1;
            end
            chg = 0;
            if (mode_wr) begin
                nn = mode_code[3] ? 12 : 4 + int'(mode_code[2:0]);
                if (nn != m_n) begin chg = 1; m_n = nn; m_on = 0; end
            end
            if (ctl_wr && !chg) begin m_on = int'(ctl_on); m_dim = int'(ctl_dim); end
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            logic [23:0] es;
            logic [11:0] eg;
            logic [7:0]  eh;
            logic        ek;
            bit lit;
            lit = (m_on != 0) && (m_slot < m_n) && (m_sub != 0) && (m_sub <= width_of(m_dim));
            for (int s = 0; s < 24; s++)
                es[s] = lit && mem[3 * m_slot + s / 8][s % 8];
            for (int g = 0; g < 12; g++)
                eg[g] = (m_on != 0) && (m_slot < m_n) && (g == m_slot);
            for (int j = 0; j < 8; j++)
                eh[j] = (j < 12 - m_n) ? es[16 + j] : eg[11 - j];
            ek = (m_on != 0) && (m_slot == m_n);
            chk(seg_o === es[15:0], "R5 segment pins", 32'(seg_o), 32'(es[15:0]));
            chk(grid_o === eg[3:0], "R2 grid pins", 32'(grid_o), 32'(eg[3:0]));
            chk(shr_o === eh, "R7 shared pins", 32'(shr_o), 32'(eh));
            chk(key_slot_o === ek, "R8 key slot", 32'(key_slot_o), 32'(ek));
        end
    end

    task automatic align;
        do @(posedge clk); while (tcnt != 0);
        @(negedge clk);
    endtask

    task automatic wr_mode(input logic [3:0] c);
        align();
        mode_wr = 1; mode_code = c;
        @(negedge clk);
        mode_wr = 0;
    endtask

    task automatic wr_ctl(input bit on, input logic [2:0] d);
        align();
        ctl_wr = 1; ctl_on = on; ctl_dim = d;
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic frame_len(output int len);
        int i;
        logic prev;
        len = 0;
        prev = key_slot_o;
        for (i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (key_slot_o && !prev) break;
            prev = key_slot_o;
        end
        prev = key_slot_o;
        for (i = 0; i < 5000; i++) begin
            @(negedge clk);
            len++;
            if (key_slot_o && !prev) break;
            prev = key_slot_o;
        end
    endtask

    task automatic lit_count(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < (n + 1) * 128; i++) begin
            @(negedge clk);
            if (grid_o[0] && seg_o != 16'd0) cnt++;
        end
    endtask

    initial begin
        int len, cnt;
        repeat (4) @(negedge clk);
        chk(seg_o == 0 && shr_o == 0 && grid_o == 0 && !key_slot_o,
            "R1 outputs dark at reset", {seg_o, shr_o, grid_o, 3'b0, key_slot_o}, 32'd0);
        rst_n = 1;
        cmp_en = 1;
        repeat (20) @(negedge clk);
        chk(seg_o == 0 && grid_o == 0 && !key_slot_o, "R1 off after reset",
            {16'd0, seg_o}, 32'd0);

        // R1: default 12 grids, dimming 0
        wr_ctl(1, 3'd0);
        chk(grid_o == 4'b0001, "R4 grid 1 right after switch-on", 32'(grid_o), 32'd1);
        frame_len(len);
        chk(len == 13 * 128, "R1 default frame of 13 slots", len, 13 * 128);
        lit_count(12, cnt);
        chk(cnt == 1 * 8, "R6 dim code 0 width", cnt, 8);

        wr_ctl(1, 3'd7);
        frame_len(len);
        lit_count(12, cnt);
        chk(cnt == 14 * 8, "R6 dim code 7 width", cnt, 14 * 8);

        // R3: changing mode forces off
        wr_mode(4'd0);
        chk(grid_o == 0 && seg_o == 0 && shr_o == 0 && !key_slot_o,
            "R3 mode change turns display off", {shr_o, grid_o}, 32'd0);
        repeat (300) @(negedge clk);
        chk(grid_o == 0 && !key_slot_o, "R3 stays off after mode change",
            {grid_o, key_slot_o}, 32'd0);

        wr_ctl(1, 3'd3);
        frame_len(len);
        chk(len == 5 * 128, "R2 frame of 5 slots for code 0", len, 5 * 128);
        lit_count(4, cnt);
        chk(cnt == 10 * 8, "R6 dim code 3 width", cnt, 10 * 8);

        // R3: same mode keeps running
        wr_mode(4'd0);
        chk(grid_o != 0 || key_slot_o, "R3 same mode leaves display on",
            {grid_o, key_slot_o}, 32'd1);
        frame_len(len);
        chk(len == 5 * 128, "R3 frame unchanged after same mode", len, 5 * 128);

        // split pool
        wr_mode(4'd3);
        wr_ctl(1, 3'd5);
        frame_len(len);
        chk(len == 8 * 128, "R2 frame of 8 slots for code 3", len, 8 * 128);
        lit_count(7, cnt);
        chk(cnt == 12 * 8, "R6 dim code 5 width", cnt, 12 * 8);

        // R4: control off then on
        wr_ctl(0, 3'd5);
        chk(grid_o == 0 && shr_o == 0 && seg_o == 0, "R4 control off darkens",
            {shr_o, grid_o}, 32'd0);
        repeat (200) @(negedge clk);
        wr_ctl(1, 3'd5);
        chk(grid_o == 4'b0001 && seg_o == 0, "R4 restart in slot 0 sub 0",
            {seg_o, grid_o}, 32'd1);
        frame_len(len);

        // code with bit 3 set: all shared pins are grids
        wr_mode(4'd9);
        chk(grid_o == 0, "R3 change to 12 grids turns off", 32'(grid_o), 32'd0);
        wr_ctl(1, 3'd2);
        frame_len(len);
        chk(len == 13 * 128, "R2 code 9 gives 12 grids", len, 13 * 128);
        wr_mode(4'd15);
        chk(grid_o != 0 || shr_o != 0 || key_slot_o, "R3 code 15 same as 9",
            {shr_o, grid_o}, 32'd1);
        frame_len(len);
        chk(len == 13 * 128, "R2 code 15 gives 12 grids", len, 13 * 128);

        // R3: simultaneous changing mode and control-on
        align();
        mode_wr = 1; mode_code = 4'd1; ctl_wr = 1; ctl_on = 1; ctl_dim = 3'd7;
        @(negedge clk);
        mode_wr = 0; ctl_wr = 0;
        chk(grid_o == 0 && shr_o == 0 && !key_slot_o, "R3 control dropped on mode change",
            {shr_o, grid_o}, 32'd0);
        wr_ctl(1, 3'd1);
        frame_len(len);
        chk(len == 6 * 128, "R2 frame of 6 slots for code 1", len, 6 * 128);
        frame_len(len);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule